// File: doc/BRIEF.md
# Priority Offload Request Buffer

This block sits in front of one high-performance core and collects requests from small cores that want a contended code region run on the fast core. Each request names the region by an identifier and carries the entry address, the stack pointer and the number of the core that sent it. Requests go into free slots. While the fast core reports that it is free, the buffer picks the waiting request whose region currently has the largest waiting-cycle count and offers it to the fast core.

The waiting-cycle counts come from outside the block. The buffer shows the region identifier held in each slot. An external table answers with one priority per slot, and the buffer reads that answer in the cycle it picks a winner. An offered request can end in one of two ways. If the fast core takes it and later reports completion, a done message goes back to the sender. If the fast core refuses it because the region's lock is held, the request leaves the buffer and goes back to the sender, which then runs the region itself. Done and bounce messages share one output port, and a tag bit tells them apart.

The controller has three states. `ST_IDLE` waits for a request and a free core. `ST_OFFER` presents the picked request. `ST_RUN` waits for completion. The transitions are:
- pick: `ST_IDLE` to `ST_OFFER`.
- take: `ST_OFFER` to `ST_RUN`.
- bounce: `ST_OFFER` to `ST_IDLE`.
- finish: `ST_RUN` to `ST_IDLE`.
- hold: any state stays where it is.

Top module: `offload_sched_buf`

## Requirements
- R1: After reset, every slot is empty. `ins_ready` is 1, and `issue_valid_o` and `msg_valid_o` are 0.
- R2: An accepted insert (`ins_valid` and `ins_ready` both high at a clock edge) writes its fields into the lowest-numbered empty slot. From the next cycle, that slot's bit in `slot_vld_o` is 1 and its identifier is shown at `slot_bid_o[k*BID_W +: BID_W]`.
- R3: `ins_ready` is 0 exactly when every slot is occupied. An insert offered while `ins_ready` is 0 leaves all slot contents unchanged.
- R4: A pick happens in `ST_IDLE` when `core_free_i` is 1 and at least one slot is valid. From the next cycle, `issue_valid_o` is 1 and the issue fields show the valid slot with the largest `slot_prio_i[k*PRIO_W +: PRIO_W]`. Priorities are read in the cycle of the pick.
- R5: When valid slots have equal largest priority, the lowest-numbered of those slots is picked.
- R6: No pick happens while `core_free_i` is 0.
- R7: When `issue_take_i` is 1 while offering, the slot is freed and the block enters `ST_RUN`. No message is sent, and `issue_valid_o` is 0 from the next cycle.
- R8: When `run_done_i` is 1 in `ST_RUN`, the next cycle carries a one-cycle message with `msg_bounce_o`=0. The message holds the core number and identifier of the request that was taken. Its address fields are 0.
- R9: When `issue_reject_i` is 1 (and `issue_take_i` is 0) while offering, the slot is freed. The next cycle carries a one-cycle message with `msg_bounce_o`=1 and all four fields of the refused request.
- R10: While neither `issue_take_i` nor `issue_reject_i` is high, the offered request and its fields stay unchanged, even if priorities change.
- R11: `run_done_i` outside `ST_RUN` produces no message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_valid | input | 1 | Insert request |
| ins_bid | input | BID_W | Region identifier of the request |
| ins_pc | input | ADDR_W | Entry address of the region |
| ins_sp | input | ADDR_W | Stack pointer of the sender |
| ins_core | input | CORE_W | Sending core number |
| ins_ready | output | 1 | A slot is free |
| slot_vld_o | output | SLOTS | Occupancy, one bit per slot |
| slot_bid_o | output | SLOTS*BID_W | Identifier held in each slot |
| slot_prio_i | input | SLOTS*PRIO_W | Waiting-cycle priority for each slot |
| core_free_i | input | 1 | Fast core can accept work |
| issue_valid_o | output | 1 | A request is offered |
| issue_bid_o | output | BID_W | Offered identifier |
| issue_pc_o | output | ADDR_W | Offered entry address |
| issue_sp_o | output | ADDR_W | Offered stack pointer |
| issue_core_o | output | CORE_W | Offered sender |
| issue_take_i | input | 1 | Fast core runs the offered request |
| issue_reject_i | input | 1 | Fast core refuses the offered request |
| run_done_i | input | 1 | Fast core finished the running request |
| msg_valid_o | output | 1 | Message to a small core |
| msg_bounce_o | output | 1 | Tag: 1 bounce, 0 done |
| msg_core_o | output | CORE_W | Destination core |
| msg_bid_o | output | BID_W | Identifier of the request |
| msg_pc_o | output | ADDR_W | Entry address (bounce only) |
| msg_sp_o | output | ADDR_W | Stack pointer (bounce only) |

## Verification
The hardest situation to reach is one where priorities tie across several occupied slots and then change while a request is already on offer. That situation shows whether priorities are read only at pick time and whether the lowest slot wins a tie. The stimulus fills every slot with the fast core held busy, then sets equal counts for two identifiers. It releases the core for one cycle and raises the losing count while the offer is held. A long random phase follows. It draws identifiers from a small set so that ties and slot reuse happen often, and it mixes inserts, refusals and completions, with each cycle compared against a behavioural model.

// File: rtl/osb_pkg.sv
package osb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_OFFER = 2'd1,
        ST_RUN   = 2'd2
    } osb_state_e;

    localparam logic MSG_KIND_DONE   = 1'b0;
    localparam logic MSG_KIND_BOUNCE = 1'b1;

endpackage

// File: rtl/osb_store.sv
module osb_store #(
    parameter int SLOTS  = 4,
    parameter int BID_W  = 8,
    parameter int ADDR_W = 32,
    parameter int CORE_W = 6
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ins_en_i,
    input  logic [BID_W-1:0]          ins_bid_i,
    input  logic [ADDR_W-1:0]         ins_pc_i,
    input  logic [ADDR_W-1:0]         ins_sp_i,
    input  logic [CORE_W-1:0]         ins_core_i,
    input  logic                      clr_en_i,
    input  logic [$clog2(SLOTS)-1:0]  clr_idx_i,
    output logic [SLOTS-1:0]          vld_o,
    output logic [SLOTS*BID_W-1:0]    bid_o,
    output logic [SLOTS*ADDR_W-1:0]   pc_o,
    output logic [SLOTS*ADDR_W-1:0]   sp_o,
    output logic [SLOTS*CORE_W-1:0]   core_o,
    output logic                      full_o
);
    localparam int IDX_W = $clog2(SLOTS);

    logic [IDX_W-1:0] free_idx;
    logic             free_found;

    // lowest empty slot receives the next insert
    always_comb begin
        free_idx   = '0;
        free_found = 1'b0;
        for (int i = 0; i < SLOTS; i++) begin
            if (!vld_o[i] && !free_found) begin
                free_idx   = IDX_W'(i);
                free_found = 1'b1;
            end
        end
    end

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        logic              vld_q;
        logic [BID_W-1:0]  bid_q;
        logic [ADDR_W-1:0] pc_q;
        logic [ADDR_W-1:0] sp_q;
        logic [CORE_W-1:0] core_q;
        logic              wr_here;
        logic              clr_here;

        assign wr_here  = ins_en_i && (free_idx == IDX_W'(g));
        assign clr_here = clr_en_i && (clr_idx_i == IDX_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vld_q <= 1'b0;
            end else if (clr_here) begin
                vld_q <= 1'b0;
            end else if (wr_here) begin
                vld_q <= 1'b1;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bid_q  <= '0;
                pc_q   <= '0;
                sp_q   <= '0;
                core_q <= '0;
            end else if (wr_here) begin
                bid_q  <= ins_bid_i;
                pc_q   <= ins_pc_i;
                sp_q   <= ins_sp_i;
                core_q <= ins_core_i;
            end
        end

        assign vld_o[g]                     = vld_q;
        assign bid_o[g*BID_W +: BID_W]      = bid_q;
        assign pc_o[g*ADDR_W +: ADDR_W]     = pc_q;
        assign sp_o[g*ADDR_W +: ADDR_W]     = sp_q;
        assign core_o[g*CORE_W +: CORE_W]   = core_q;
    end

    assign full_o = &vld_o;

    // R2: an insert without a removal grows occupancy by exactly one
    p_insert_grows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_en_i && !clr_en_i) |=> ($countones(vld_o) == $past($countones(vld_o)) + 1));

    // R7: only an occupied slot is ever freed
    p_clear_live_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en_i |-> vld_o[clr_idx_i]);

endmodule

// File: rtl/osb_pick.sv
module osb_pick #(
    parameter int SLOTS  = 4,
    parameter int PRIO_W = 16
) (
    input  logic [SLOTS-1:0]          vld_i,
    input  logic [SLOTS*PRIO_W-1:0]   prio_i,
    output logic                      any_o,
    output logic [$clog2(SLOTS)-1:0]  idx_o
);
    localparam int IDX_W = $clog2(SLOTS);

    logic [PRIO_W-1:0] best;

    // strict greater-than keeps the lower slot on a tie
    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        best  = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if (vld_i[i] && (!any_o || prio_i[i*PRIO_W +: PRIO_W] > best)) begin
                any_o = 1'b1;
                idx_o = IDX_W'(i);
                best  = prio_i[i*PRIO_W +: PRIO_W];
            end
        end
    end

endmodule

// File: rtl/osb_msg.sv
module osb_msg #(
    parameter int BID_W  = 8,
    parameter int ADDR_W = 32,
    parameter int CORE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              send_done_i,
    input  logic              send_bounce_i,
    input  logic [CORE_W-1:0] done_core_i,
    input  logic [BID_W-1:0]  done_bid_i,
    input  logic [CORE_W-1:0] bnc_core_i,
    input  logic [BID_W-1:0]  bnc_bid_i,
    input  logic [ADDR_W-1:0] bnc_pc_i,
    input  logic [ADDR_W-1:0] bnc_sp_i,
    output logic              msg_valid_o,
    output logic              msg_bounce_o,
    output logic [CORE_W-1:0] msg_core_o,
    output logic [BID_W-1:0]  msg_bid_o,
    output logic [ADDR_W-1:0] msg_pc_o,
    output logic [ADDR_W-1:0] msg_sp_o
);
    import osb_pkg::*;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            msg_valid_o  <= 1'b0;
            msg_bounce_o <= MSG_KIND_DONE;
            msg_core_o   <= '0;
            msg_bid_o    <= '0;
            msg_pc_o     <= '0;
            msg_sp_o     <= '0;
        end else if (send_bounce_i) begin
            msg_valid_o  <= 1'b1;
            msg_bounce_o <= MSG_KIND_BOUNCE;
            msg_core_o   <= bnc_core_i;
            msg_bid_o    <= bnc_bid_i;
            msg_pc_o     <= bnc_pc_i;
            msg_sp_o     <= bnc_sp_i;
        end else if (send_done_i) begin
            msg_valid_o  <= 1'b1;
            msg_bounce_o <= MSG_KIND_DONE;
            msg_core_o   <= done_core_i;
            msg_bid_o    <= done_bid_i;
            msg_pc_o     <= '0;
            msg_sp_o     <= '0;
        end else begin
            msg_valid_o  <= 1'b0;
        end
    end

endmodule

// File: rtl/offload_sched_buf.sv
module offload_sched_buf #(
    parameter int SLOTS  = 4,
    parameter int BID_W  = 8,
    parameter int ADDR_W = 32,
    parameter int CORE_W = 6,
    parameter int PRIO_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ins_valid,
    input  logic [BID_W-1:0]         ins_bid,
    input  logic [ADDR_W-1:0]        ins_pc,
    input  logic [ADDR_W-1:0]        ins_sp,
    input  logic [CORE_W-1:0]        ins_core,
    output logic                     ins_ready,
    output logic [SLOTS-1:0]         slot_vld_o,
    output logic [SLOTS*BID_W-1:0]   slot_bid_o,
    input  logic [SLOTS*PRIO_W-1:0]  slot_prio_i,
    input  logic                     core_free_i,
    output logic                     issue_valid_o,
    output logic [BID_W-1:0]         issue_bid_o,
    output logic [ADDR_W-1:0]        issue_pc_o,
    output logic [ADDR_W-1:0]        issue_sp_o,
    output logic [CORE_W-1:0]        issue_core_o,
    input  logic                     issue_take_i,
    input  logic                     issue_reject_i,
    input  logic                     run_done_i,
    output logic                     msg_valid_o,
    output logic                     msg_bounce_o,
    output logic [CORE_W-1:0]        msg_core_o,
    output logic [BID_W-1:0]         msg_bid_o,
    output logic [ADDR_W-1:0]        msg_pc_o,
    output logic [ADDR_W-1:0]        msg_sp_o
);
    import osb_pkg::*;

    localparam int IDX_W = $clog2(SLOTS);

    osb_state_e state_q, state_d;
    logic [IDX_W-1:0]  sel_q;
    logic [CORE_W-1:0] own_core_q;
    logic [BID_W-1:0]  own_bid_q;

    logic                    full;
    logic                    ins_en;
    logic                    clr_en;
    logic                    load_sel;
    logic                    take_now;
    logic                    send_done;
    logic                    send_bounce;
    logic                    pick_any;
    logic [IDX_W-1:0]        pick_idx;
    logic [SLOTS*ADDR_W-1:0] pc_flat;
    logic [SLOTS*ADDR_W-1:0] sp_flat;
    logic [SLOTS*CORE_W-1:0] core_flat;
    logic [BID_W-1:0]        sel_bid;
    logic [ADDR_W-1:0]       sel_pc;
    logic [ADDR_W-1:0]       sel_sp;
    logic [CORE_W-1:0]       sel_core;

    assign ins_ready = !full;
    assign ins_en    = ins_valid && !full;

    osb_store #(
        .SLOTS(SLOTS), .BID_W(BID_W), .ADDR_W(ADDR_W), .CORE_W(CORE_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .ins_en_i(ins_en), .ins_bid_i(ins_bid), .ins_pc_i(ins_pc),
        .ins_sp_i(ins_sp), .ins_core_i(ins_core),
        .clr_en_i(clr_en), .clr_idx_i(sel_q),
        .vld_o(slot_vld_o), .bid_o(slot_bid_o), .pc_o(pc_flat),
        .sp_o(sp_flat), .core_o(core_flat), .full_o(full)
    );

    osb_pick #(
        .SLOTS(SLOTS), .PRIO_W(PRIO_W)
    ) u_pick (
        .vld_i(slot_vld_o), .prio_i(slot_prio_i),
        .any_o(pick_any), .idx_o(pick_idx)
    );

    assign sel_bid  = slot_bid_o[sel_q*BID_W +: BID_W];
    assign sel_pc   = pc_flat[sel_q*ADDR_W +: ADDR_W];
    assign sel_sp   = sp_flat[sel_q*ADDR_W +: ADDR_W];
    assign sel_core = core_flat[sel_q*CORE_W +: CORE_W];

    // state register and the registers loaded by transitions
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            sel_q      <= '0;
            own_core_q <= '0;
            own_bid_q  <= '0;
        end else begin
            state_q <= state_d;
            if (load_sel) begin
                sel_q <= pick_idx;
            end
            if (take_now) begin
                own_core_q <= sel_core;
                own_bid_q  <= sel_bid;
            end
        end
    end

    // transitions: pick, take, bounce, finish, hold
    always_comb begin
        state_d     = state_q;
        load_sel    = 1'b0;
        clr_en      = 1'b0;
        take_now    = 1'b0;
        send_done   = 1'b0;
        send_bounce = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (core_free_i && pick_any) begin
                    state_d  = ST_OFFER;
                    load_sel = 1'b1;
                end
            end
            ST_OFFER: begin
                if (issue_take_i) begin
                    state_d  = ST_RUN;
                    clr_en   = 1'b1;
                    take_now = 1'b1;
                end else if (issue_reject_i) begin
                    state_d     = ST_IDLE;
                    clr_en      = 1'b1;
                    send_bounce = 1'b1;
                end
            end
            ST_RUN: begin
                if (run_done_i) begin
                    state_d   = ST_IDLE;
                    send_done = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs of the offer stage
    always_comb begin
        issue_valid_o = (state_q == ST_OFFER);
        issue_bid_o   = sel_bid;
        issue_pc_o    = sel_pc;
        issue_sp_o    = sel_sp;
        issue_core_o  = sel_core;
    end

    osb_msg #(
        .BID_W(BID_W), .ADDR_W(ADDR_W), .CORE_W(CORE_W)
    ) u_msg (
        .clk(clk), .rst_n(rst_n),
        .send_done_i(send_done), .send_bounce_i(send_bounce),
        .done_core_i(own_core_q), .done_bid_i(own_bid_q),
        .bnc_core_i(sel_core), .bnc_bid_i(sel_bid),
        .bnc_pc_i(sel_pc), .bnc_sp_i(sel_sp),
        .msg_valid_o(msg_valid_o), .msg_bounce_o(msg_bounce_o),
        .msg_core_o(msg_core_o), .msg_bid_o(msg_bid_o),
        .msg_pc_o(msg_pc_o), .msg_sp_o(msg_sp_o)
    );

    // R6: without a free core an idle controller offers nothing
    p_hold_when_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!issue_valid_o && !core_free_i) |=> !issue_valid_o);

    // R10: an unanswered offer keeps its content
    p_offer_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid_o && !issue_take_i && !issue_reject_i) |=>
        (issue_valid_o && $stable(issue_core_o) && $stable(issue_pc_o) && $stable(issue_bid_o)));

    // R7: a taken request produces no message
    p_take_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid_o && issue_take_i) |=> (!msg_valid_o && !issue_valid_o));

    // R9: a refused request comes back tagged as a bounce
    p_bounce_tag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid_o && !issue_take_i && issue_reject_i) |=>
        (msg_valid_o && msg_bounce_o && msg_core_o == $past(issue_core_o)));

    // R8: completion in the run state returns a done message
    p_done_msg_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && run_done_i) |=> (msg_valid_o && !msg_bounce_o));

    // R11: completion outside the run state is silent
    p_stray_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_RUN && !(issue_valid_o && issue_reject_i)) |=> !msg_valid_o);

endmodule

// File: tb/offload_sched_buf_bench.sv
`timescale 1ns/1ps
module offload_sched_buf_bench;
    localparam int SLOTS  = 4;
    localparam int BID_W  = 8;
    localparam int ADDR_W = 32;
    localparam int CORE_W = 6;
    localparam int PRIO_W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic                    ins_valid = 0;
    logic [BID_W-1:0]        ins_bid = 0;
    logic [ADDR_W-1:0]       ins_pc = 0;
    logic [ADDR_W-1:0]       ins_sp = 0;
    logic [CORE_W-1:0]       ins_core = 0;
    logic                    ins_ready;
    logic [SLOTS-1:0]        slot_vld;
    logic [SLOTS*BID_W-1:0]  slot_bid;
    logic [SLOTS*PRIO_W-1:0] slot_prio;
    logic                    core_free = 0;
    logic                    issue_valid;
    logic [BID_W-1:0]        issue_bid;
    logic [ADDR_W-1:0]       issue_pc;
    logic [ADDR_W-1:0]       issue_sp;
    logic [CORE_W-1:0]       issue_core;
    logic                    take = 0;
    logic                    reject = 0;
    logic                    done = 0;
    logic                    msg_valid;
    logic                    msg_bounce;
    logic [CORE_W-1:0]       msg_core;
    logic [BID_W-1:0]        msg_bid;
    logic [ADDR_W-1:0]       msg_pc;
    logic [ADDR_W-1:0]       msg_sp;

    logic [PRIO_W-1:0] waitc [256];

    // bench acts as the external waiting-cycle table
    always_comb begin
        for (int i = 0; i < SLOTS; i++)
            slot_prio[i*PRIO_W +: PRIO_W] = waitc[slot_bid[i*BID_W +: BID_W]];
    end

    offload_sched_buf #(
        .SLOTS(SLOTS), .BID_W(BID_W), .ADDR_W(ADDR_W), .CORE_W(CORE_W), .PRIO_W(PRIO_W)
    ) u_offload_sched_buf (
        .clk(clk), .rst_n(rst_n),
        .ins_valid(ins_valid), .ins_bid(ins_bid), .ins_pc(ins_pc), .ins_sp(ins_sp),
        .ins_core(ins_core), .ins_ready(ins_ready),
        .slot_vld_o(slot_vld), .slot_bid_o(slot_bid), .slot_prio_i(slot_prio),
        .core_free_i(core_free),
        .issue_valid_o(issue_valid), .issue_bid_o(issue_bid), .issue_pc_o(issue_pc),
        .issue_sp_o(issue_sp), .issue_core_o(issue_core),
        .issue_take_i(take), .issue_reject_i(reject), .run_done_i(done),
        .msg_valid_o(msg_valid), .msg_bounce_o(msg_bounce), .msg_core_o(msg_core),
        .msg_bid_o(msg_bid), .msg_pc_o(msg_pc), .msg_sp_o(msg_sp)
    );

    int checks = 0;
    int failures = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int  m_st;            // 0 idle, 1 offer, 2 run
    bit  m_vld [SLOTS];
    int  m_bid [SLOTS];
    longint m_pc [SLOTS];
    longint m_sp [SLOTS];
    int  m_core [SLOTS];
    int  m_sel, m_own_core, m_own_bid;
    bit  mm_v, mm_b;
    int  mm_core, mm_bid;
    longint mm_pc, mm_sp;
    int  f_idx, b_idx;
    int  b_pr;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_sel = 0; mm_v = 0; mm_b = 0;
            for (int i = 0; i < SLOTS; i++) m_vld[i] = 0;
        end else begin
            f_idx = -1;
            for (int i = 0; i < SLOTS; i++) if (!m_vld[i] && f_idx < 0) f_idx = i;
            mm_v = 0;
            case (m_st)
                0: if (core_free) begin
                    b_idx = -1; b_pr = -1;
                    for (int i = 0; i < SLOTS; i++)
                        if (m_vld[i] && int'(waitc[m_bid[i]]) > b_pr) begin
                            b_pr = int'(waitc[m_bid[i]]); b_idx = i;
                        end
                    if (b_idx >= 0) begin m_sel = b_idx; m_st = 1; end
                end
                1: if (take) begin
                    m_vld[m_sel] = 0; m_own_core = m_core[m_sel]; m_own_bid = m_bid[m_sel]; m_st = 2;
                end else if (reject) begin
                    m_vld[m_sel] = 0; mm_v = 1; mm_b = 1; mm_core = m_core[m_sel];
                    mm_bid = m_bid[m_sel]; mm_pc = m_pc[m_sel]; mm_sp = m_sp[m_sel]; m_st = 0;
                end
                default: if (done) begin
                    mm_v = 1; mm_b = 0; mm_core = m_own_core; mm_bid = m_own_bid;
                    mm_pc = 0; mm_sp = 0; m_st = 0;
                end
            endcase
            if (ins_valid && f_idx >= 0) begin
                m_vld[f_idx] = 1; m_bid[f_idx] = int'(ins_bid); m_pc[f_idx] = longint'(ins_pc);
                m_sp[f_idx] = longint'(ins_sp); m_core[f_idx] = int'(ins_core);
            end
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            bit all_full;
            all_full = 1;
            for (int i = 0; i < SLOTS; i++) begin
                if (!m_vld[i]) all_full = 0;
                chk(slot_vld[i] == m_vld[i], "R2 slot valid", slot_vld[i], m_vld[i]);
                if (m_vld[i])
                    chk(int'(slot_bid[i*BID_W +: BID_W]) == m_bid[i], "R2 slot id",
                        slot_bid[i*BID_W +: BID_W], m_bid[i]);
            end
            chk(ins_ready == !all_full, "R3 ready", ins_ready, !all_full);
            chk(issue_valid == (m_st == 1), "R4 offer valid", issue_valid, m_st == 1);
            if (m_st == 1) begin
                chk(int'(issue_core) == m_core[m_sel], "R4 offer core", issue_core, m_core[m_sel]);
                chk(int'(issue_bid) == m_bid[m_sel], "R4 offer id", issue_bid, m_bid[m_sel]);
                chk(longint'(issue_pc) == m_pc[m_sel], "R4 offer pc", issue_pc, m_pc[m_sel]);
                chk(longint'(issue_sp) == m_sp[m_sel], "R4 offer sp", issue_sp, m_sp[m_sel]);
            end
            chk(msg_valid == mm_v, "R8 message valid", msg_valid, mm_v);
            if (mm_v) begin
                chk(msg_bounce == mm_b, "R9 message tag", msg_bounce, mm_b);
                chk(int'(msg_core) == mm_core, "R8 message core", msg_core, mm_core);
                chk(int'(msg_bid) == mm_bid, "R8 message id", msg_bid, mm_bid);
                chk(longint'(msg_pc) == mm_pc, "R9 message pc", msg_pc, mm_pc);
                chk(longint'(msg_sp) == mm_sp, "R9 message sp", msg_sp, mm_sp);
            end
        end
    end

    task automatic step();
        @(negedge clk); #1;
    endtask

    task automatic put(input int core, input int bid, input logic [31:0] pc, input logic [31:0] sp);
        ins_valid = 1; ins_core = CORE_W'(core); ins_bid = BID_W'(bid); ins_pc = pc; ins_sp = sp;
        step();
        ins_valid = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) waitc[i] = '0;
        step(); step(); step();
        rst_n = 1;
        step();
        // R1 reset state
        chk(ins_ready == 1, "R1 ready", ins_ready, 1);
        chk(slot_vld == '0, "R1 empty", slot_vld, 0);
        chk(issue_valid == 0, "R1 no offer", issue_valid, 0);
        chk(msg_valid == 0, "R1 no message", msg_valid, 0);

        // fill all slots while the fast core is busy
        put(3, 10, 32'h100, 32'h900);
        put(1, 11, 32'h110, 32'h910);
        put(2, 12, 32'h120, 32'h920);
        put(0, 13, 32'h130, 32'h930);
        chk(slot_vld == 4'hF, "R2 all filled", slot_vld, 4'hF);
        chk(slot_bid == {8'd13, 8'd12, 8'd11, 8'd10}, "R2 slot order", slot_bid, 32'h0D0C0B0A);
        chk(ins_ready == 0, "R3 full", ins_ready, 0);
        chk(issue_valid == 0, "R6 no pick while busy", issue_valid, 0);

        put(5, 99, 32'hDEAD, 32'hBEEF);
        chk(slot_bid == {8'd13, 8'd12, 8'd11, 8'd10}, "R3 refused insert", slot_bid, 32'h0D0C0B0A);

        // tie between slot 1 and slot 3
        waitc[10] = 5; waitc[11] = 50; waitc[12] = 20; waitc[13] = 50;
        core_free = 1; step(); core_free = 0;
        chk(issue_valid == 1, "R4 pick", issue_valid, 1);
        chk(issue_core == 1, "R5 tie lowest slot", issue_core, 1);
        waitc[13] = 200;
        step(); step();
        chk(issue_core == 1 && issue_pc == 32'h110, "R10 offer held", issue_core, 1);

        take = 1; step(); take = 0;
        chk(issue_valid == 0, "R7 offer ends", issue_valid, 0);
        chk(slot_vld == 4'b1101, "R7 slot freed", slot_vld, 4'b1101);
        chk(msg_valid == 0, "R7 no message", msg_valid, 0);

        done = 1; step(); done = 0;
        chk(msg_valid == 1 && msg_bounce == 0, "R8 done message", {msg_valid, msg_bounce}, 2'b10);
        chk(msg_core == 1 && msg_bid == 11, "R8 done target", msg_core, 1);
        step();
        chk(msg_valid == 0, "R8 single cycle", msg_valid, 0);

        done = 1; step(); done = 0;
        chk(msg_valid == 0, "R11 stray done", msg_valid, 0);

        waitc[13] = 1;
        core_free = 1; step(); core_free = 0;
        chk(issue_core == 2 && issue_bid == 12, "R4 highest count", issue_core, 2);
        reject = 1; step(); reject = 0;
        chk(msg_valid == 1 && msg_bounce == 1, "R9 bounce", {msg_valid, msg_bounce}, 2'b11);
        chk(msg_core == 2 && msg_pc == 32'h120 && msg_sp == 32'h920, "R9 bounce fields", msg_pc, 32'h120);
        chk(slot_vld == 4'b1001, "R9 slot freed", slot_vld, 4'b1001);

        // random mix, checked against the model every cycle
        for (int i = 0; i < 16; i++) waitc[i] = PRIO_W'($urandom_range(0, 7));
        for (int n = 0; n < 3000; n++) begin
            ins_valid = ($urandom_range(0, 2) == 0);
            ins_bid   = BID_W'($urandom_range(0, 15));
            ins_core  = CORE_W'($urandom_range(0, 63));
            ins_pc    = $urandom;
            ins_sp    = $urandom;
            core_free = ($urandom_range(0, 1) == 1);
            take = 0; reject = 0;
            if (m_st == 1) begin
                int r;
                r = $urandom_range(0, 3);
                take = (r == 0);
                reject = (r == 1);
            end
            done = ($urandom_range(0, 3) == 0);
            if ($urandom_range(0, 4) == 0) waitc[$urandom_range(0, 15)] = PRIO_W'($urandom_range(0, 7));
            step();
        end
        ins_valid = 0; take = 0; reject = 0; done = 0; core_free = 0;
        step();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule